// File: doc/BRIEF.md
# External Memory Bus Controller

This block runs external memory read and write cycles on behalf of a 16-bit core. The core offers one request at a time: a 24-bit address, write data, two byte enables and a read/write flag. The block takes it when it signals that it can accept. It then places the low 16 address bits on a shared address/data bus and pulses an address latch enable so an external latch can hold them. It then runs the data phase with an active-low read or write strobe, and finishes with a recovery cycle. The upper eight address bits leave on a separate segment port. Each pin of that port has its own direction bit, and a pin set as input has its driver switched off.

Three configuration inputs shape the cycle. The first selects an 8-bit or 16-bit external bus. The second chooses whether the write strobe fires on every write, or only on writes that touch the low byte, with 8-bit bus writes always counting as such. The third enables the ready input: while it is high during the data phase, wait states are inserted. The core sees a one-clock done pulse at the end of the data phase. On a read, the data sampled from the bus appears in that same cycle.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset the block is idle: `ale` low, `rdN` and `wrN` high, `adOe` low, `done` low, `reqReady` high.
- R2: A request accepted while `reqReady` is high is followed by exactly one cycle with `ale` high, `adOe` high, `adOut` equal to address bits 15..0, and `reqReady` low. The next cycle starts the data phase.
- R3: In the data phase of a read, `rdN` is low, `wrN` stays high and `adOe` is low, so the bus is released. In the cycle with `done` high, `rdData` equals `adIn`.
- R4: In the data phase of a write, `adOe` is high and `adOut` carries the write data. A byte lane whose enable is clear is driven as zero: `reqBe[0]` covers bits 7..0 and `reqBe[1]` covers bits 15..8.
- R5: With `wrLowMode` = 0, `wrN` is low through the data phase of every write.
- R6: With `wrLowMode` = 1, `wrN` goes low only when `busIs8` = 1 or `reqBe[0]` = 1. Otherwise the write cycle runs its full length with `wrN` high.
- R7: With `readyEn` = 1, each data-phase cycle that sees `readyIn` high adds a wait state with the strobe held low. `done` rises in the first data-phase cycle in which `readyIn` is low.
- R8: With `readyEn` = 0, `readyIn` is ignored. Every access takes four cycles (address, data, recovery, idle), with `done` in the data cycle.
- R9: `rdN` and `wrN` are never low in the same cycle, and neither is low while `ale` is high.
- R10: `done` is high for exactly one clock per access. After it comes one recovery cycle with both strobes high and `adOe` low, and then `reqReady` returns high.
- R11: `segOut` carries address bits 23..16, with bit 16 in position 0, from the address phase until the next access. `segOe` follows `segDir` bit for bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Core presents a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Access address |
| reqWdata | input | 16 | Write data |
| reqBe | input | 2 | Byte enables, bit 0 = low byte |
| reqReady | output | 1 | Block is idle and takes a request |
| done | output | 1 | One-clock end-of-data-phase pulse |
| rdData | output | 16 | Read data, valid with done on reads |
| busIs8 | input | 1 | External bus is 8 bits wide |
| wrLowMode | input | 1 | Write strobe only for low-byte writes |
| readyEn | input | 1 | Enables wait states from readyIn |
| segDir | input | 8 | Per-pin direction of the segment port, 1 = output |
| adOut | output | 16 | Shared bus output value |
| adOe | output | 1 | Shared bus output enable |
| adIn | input | 16 | Shared bus input value |
| ale | output | 1 | Address latch enable |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| readyIn | input | 1 | Wait request, high = stretch |
| segOut | output | 8 | Segment address bits 23..16 |
| segOe | output | 8 | Segment port output enables |

## Verification
Two things can happen in the same clock: a stretch request on `readyIn` and the end of the data phase. Whether `done` fires depends only on the level of `readyIn` in that very cycle. The bench draws random wait counts from zero upward and drives `readyIn` high with `readyEn` clear, so both meetings occur. In every strobe cycle it judges `done`, the strobes and the bus against a per-cycle model built from the wait count. A zero wait count makes the first data cycle also the last, which tests that the release and the done pulse share that cycle.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DATA,
    PH_WAIT,
    PH_RECOVER
  } phase_t;

  typedef struct packed {
    logic latchReq;
    logic driveAddr;
    logic driveData;
    logic capture;
  } dpCtl_t;
endpackage

// File: rtl/ebc_ctrl.sv
module ebc_ctrl
  import ebc_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   writeQ,
  input  logic   beLowQ,
  input  logic   busIs8,
  input  logic   wrLowMode,
  input  logic   readyEn,
  input  logic   readyIn,
  output dpCtl_t ctl,
  output logic   ale,
  output logic   rdN,
  output logic   wrN,
  output logic   reqReady,
  output logic   done
);
  phase_t phase, phaseNext;
  logic strobeActive, stretch, wrQualify;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  assign strobeActive = (phase == PH_DATA) || (phase == PH_WAIT);
  assign stretch      = readyEn && readyIn;
  assign wrQualify    = !wrLowMode || busIs8 || beLowQ;

  always_comb begin
    phaseNext = phase;
    case (phase)
      PH_IDLE:    if (reqValid) phaseNext = PH_ADDR;
      PH_ADDR:    phaseNext = PH_DATA;
      PH_DATA,
      PH_WAIT:    phaseNext = stretch ? PH_WAIT : PH_RECOVER;
      PH_RECOVER: phaseNext = PH_IDLE;
      default:    phaseNext = PH_IDLE;
    endcase
  end

  assign reqReady      = (phase == PH_IDLE);
  assign ale           = (phase == PH_ADDR);
  assign done          = strobeActive && !stretch;
  assign rdN           = !(strobeActive && !writeQ);
  assign wrN           = !(strobeActive && writeQ && wrQualify);
  assign ctl.latchReq  = reqReady && reqValid;
  assign ctl.driveAddr = ale;
  assign ctl.driveData = strobeActive && writeQ;
  assign ctl.capture   = done && !writeQ;
endmodule

// File: rtl/ebc_datapath.sv
module ebc_datapath
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int SEG_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] adIn,
  output logic              writeQ,
  output logic              beLowQ,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [DATA_W-1:0] rdData,
  output logic [SEG_W-1:0]  segOut
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] rdHold;
  logic [DATA_W-1:0] laneData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      writeQ <= 1'b0;
    end else if (ctl.latchReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
      writeQ <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdHold <= '0;
    else if (ctl.capture) rdHold <= adIn;
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign laneData[lane*8 +: 8] = beQ[lane] ? wdataQ[lane*8 +: 8] : 8'h00;
  end

  assign beLowQ = beQ[0];
  assign adOe   = ctl.driveAddr || ctl.driveData;
  assign adOut  = ctl.driveAddr ? addrQ[DATA_W-1:0] : laneData;
  assign rdData = ctl.capture ? adIn : rdHold;
  assign segOut = addrQ[ADDR_W-1:DATA_W];
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  localparam int LANES = DATA_W / 8,
  localparam int SEG_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqBe,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  input  logic              busIs8,
  input  logic              wrLowMode,
  input  logic              readyEn,
  input  logic [SEG_W-1:0]  segDir,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  input  logic [DATA_W-1:0] adIn,
  output logic              ale,
  output logic              rdN,
  output logic              wrN,
  input  logic              readyIn,
  output logic [SEG_W-1:0]  segOut,
  output logic [SEG_W-1:0]  segOe
);
  dpCtl_t ctl;
  logic   writeQ, beLowQ;

  ebc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .writeQ(writeQ),
    .beLowQ(beLowQ), .busIs8(busIs8), .wrLowMode(wrLowMode),
    .readyEn(readyEn), .readyIn(readyIn), .ctl(ctl), .ale(ale),
    .rdN(rdN), .wrN(wrN), .reqReady(reqReady), .done(done)
  );

  ebc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe), .adIn(adIn),
    .writeQ(writeQ), .beLowQ(beLowQ), .adOut(adOut), .adOe(adOe),
    .rdData(rdData), .segOut(segOut)
  );

  for (genvar p = 0; p < SEG_W; p++) begin : g_segPin
    assign segOe[p] = segDir[p];
  end
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic done,
  input logic readyEn,
  input logic readyIn,
  input logic adOe,
  input logic ale,
  input logic rdN,
  input logic wrN
);
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  p_ale_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    ale |-> (rdN && wrN));
  p_accept_ale_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> (ale && !reqReady));
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);
  p_read_release_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);
  p_stretch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (readyEn && readyIn) |-> !done);
  p_fixed_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ale && !readyEn) |=> (readyEn || done));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && rdN && wrN && !adOe && !reqReady));
endmodule

bind ext_bus_ctrl ebc_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .done(done), .readyEn(readyEn), .readyIn(readyIn), .adOe(adOe),
  .ale(ale), .rdN(rdN), .wrN(wrN)
);

// File: tb/ext_bus_ctrl_test.sv
`timescale 1ns/1ps
module ext_bus_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqBe = '0;
  logic        reqReady, done;
  logic [15:0] rdData;
  logic        busIs8 = 1'b0, wrLowMode = 1'b0, readyEn = 1'b0;
  logic [7:0]  segDir = '0;
  logic [15:0] adOut;
  logic        adOe;
  logic [15:0] adIn = '0;
  logic        ale, rdN, wrN;
  logic        readyIn = 1'b0;
  logic [7:0]  segOut, segOe;

  int total = 0;
  int bad = 0;

  ext_bus_ctrl uut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] laneMask(input logic [15:0] d, input logic [1:0] be);
    return {be[1] ? d[15:8] : 8'h00, be[0] ? d[7:0] : 8'h00};
  endfunction

  function automatic logic expectWrStrobe(input logic lowMode, input logic b8, input logic [1:0] be);
    return !lowMode || b8 || be[0];
  endfunction

  task automatic access(input logic wr, input logic [23:0] addr, input logic [15:0] wd,
                        input logic [1:0] be, input int waits, input logic [15:0] rdVal);
    int last;
    logic expWr;
    @(negedge clk);
    check("R10 ready before request", reqReady, 1'b1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = wd; reqBe = be;
    adIn = rdVal;
    @(negedge clk);
    reqValid = 1'b0;
    check("R2 ale", ale, 1'b1);
    check("R2 adOe", adOe, 1'b1);
    check("R2 address on bus", adOut, addr[15:0]);
    check("R2 reqReady low", reqReady, 1'b0);
    check("R9 no strobe with ale", {rdN, wrN}, 2'b11);
    check("R11 segment lines", segOut, addr[23:16]);
    check("R11 segment direction", segOe, segDir);
    last = readyEn ? waits : 0;
    expWr = expectWrStrobe(wrLowMode, busIs8, be);
    for (int i = 0; i <= last; i++) begin
      @(negedge clk);
      readyIn = readyEn ? (i < waits) : 1'b1;
      #1;
      if (wr) begin
        check("R5/R6 write strobe", wrN, !expWr);
        check("R3 no read strobe on write", rdN, 1'b1);
        check("R4 write data", adOut, laneMask(wd, be));
        check("R4 bus driven", adOe, 1'b1);
      end else begin
        check("R3 read strobe", rdN, 1'b0);
        check("R3 bus released", adOe, 1'b0);
        check("R9 no write strobe on read", wrN, 1'b1);
      end
      check(readyEn ? "R7 done timing" : "R8 readyIn ignored", done, i == last);
      if (!wr && i == last) check("R3 read data", rdData, rdVal);
    end
    @(negedge clk);
    readyIn = 1'b0;
    check("R10 recovery strobes", {rdN, wrN, adOe, done}, 4'b1100);
    check("R10 recovery not ready", reqReady, 1'b0);
    check("R11 segment held", segOut, addr[23:16]);
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check("R1 ale", ale, 1'b0);
    check("R1 strobes", {rdN, wrN}, 2'b11);
    check("R1 adOe", adOe, 1'b0);
    check("R1 done", done, 1'b0);
    check("R1 reqReady", reqReady, 1'b1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // directed corners
    segDir = 8'hA5;
    access(1'b0, 24'h12_3456, 16'h0, 2'b11, 0, 16'hBEEF);
    wrLowMode = 1'b1;
    access(1'b1, 24'hFE_0002, 16'hCAFE, 2'b10, 0, 16'h0);     // R6 no strobe
    busIs8 = 1'b1;
    access(1'b1, 24'h01_0003, 16'h1234, 2'b10, 0, 16'h0);     // R6 8-bit always
    busIs8 = 1'b0; wrLowMode = 1'b0;
    access(1'b1, 24'h80_0004, 16'h5678, 2'b10, 0, 16'h0);     // R5 every write
    readyEn = 1'b1;
    access(1'b0, 24'h7F_FFFE, 16'h0, 2'b11, 3, 16'h1357);     // R7 waits
    access(1'b1, 24'h00_0000, 16'hFFFF, 2'b01, 1, 16'h0);
    readyEn = 1'b0;
    access(1'b0, 24'hFF_FFFF, 16'h0, 2'b11, 5, 16'h2468);     // R8 ignored

    // random mix
    for (int n = 0; n < 60; n++) begin
      busIs8    = $urandom_range(0, 1);
      wrLowMode = $urandom_range(0, 1);
      readyEn   = $urandom_range(0, 1);
      segDir    = 8'($urandom);
      access($urandom_range(0, 1), 24'($urandom), 16'($urandom), 2'($urandom),
             $urandom_range(0, 4), 16'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule